// File: doc/BRIEF.md
# Four-Phase Write Handshake Pair

This block pairs a write master with a small memory-like slave. The two sides talk over a self-timed, return-to-zero handshake. A one-cycle start pulse hands the master an address and a data word. The master first puts the address, the data and a write strobe on the shared bus. Only after that does it raise request. The slave stores the word at the addressed location and then raises acknowledge. The master sees acknowledge and drops request. The slave sees request low and drops acknowledge. When the master sees acknowledge go low, it pulses done, and the transfer is complete.

Each side takes in the other side's handshake line through a synchronizer chain of configurable depth. The two sides could therefore sit on unrelated timing without changing the protocol. The handshake wires are brought out to the ports so a system can observe them. A combinational read port on the slave lets the surrounding logic inspect any stored word.

Top module: `hs_write_top`

## Requirements
- R1: While reset is high and right after it, request, acknowledge, write strobe, busy and done are all 0, and every slave word reads 0.
- R2: A start pulse while idle makes busy 1 and the write strobe 1 on the next cycle, with request still 0. Request rises only after the write strobe has been 1 for at least one cycle.
- R3: While request is 1, the bus address and bus data hold their values.
- R4: Acknowledge rises only while request is 1. The slave has stored the word by the time acknowledge is seen.
- R5: Request falls only while acknowledge is 1.
- R6: Acknowledge falls only while request is 0.
- R7: Done is high for exactly one cycle. It comes after acknowledge has returned to 0. Busy is 0 from that cycle on, and request and acknowledge are both 0 while done is high.
- R8: A start pulse while busy is ignored. The running write completes with its own address and data, no word at the ignored address changes, and no second transfer follows.
- R9: The read port returns, in the same cycle, the stored word at the read address (address width ADDR_W, word width DATA_W).
- R10: Consecutive writes each land at their own address, and a later write to the same address replaces the earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a write |
| start_addr | input | ADDR_W | Target address for the write |
| start_data | input | DATA_W | Data word for the write |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| bus_req | output | 1 | Handshake request from the master |
| bus_ack | output | 1 | Handshake acknowledge from the slave |
| bus_wr | output | 1 | Write strobe on the bus |
| bus_addr | output | ADDR_W | Address on the bus |
| bus_data | output | DATA_W | Data on the bus |
| rd_addr | input | ADDR_W | Read-port address into the slave store |
| rd_data | output | DATA_W | Word stored at rd_addr |

## Verification
The bench builds the block with a 3-bit address, 8-bit data and two synchronizer stages, which gives eight words. With eight words the bench can fill every location, overwrite one, and read all of them back in few cycles. The two-stage chains make each handshake edge take several cycles to cross. That leaves a wide window in which a stray start pulse can arrive mid-transfer, and in which the four edges can be watched for wrong ordering.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        M_IDLE     = 2'd0,
        M_SETUP    = 2'd1,
        M_WAIT_ACK = 2'd2,
        M_WAIT_REL = 2'd3
    } mst_state_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } slv_state_t;

    localparam int HS_MIN_SYNC = 2;

    function automatic int clamp_sync(input int stages);
        return (stages < HS_MIN_SYNC) ? HS_MIN_SYNC : stages;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int N = hs_pkg::clamp_sync(STAGES);

    logic [N-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[N-2:0], d};
    end

    assign q = chain[N-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
    import hs_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic              ack_in,
    output logic              req_out,
    output logic              wr_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out,
    output logic              busy,
    output logic              done
);
    mst_state_t state;
    logic       ack_s;

    hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_in),
        .q   (ack_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= M_IDLE;
            req_out  <= 1'b0;
            wr_out   <= 1'b0;
            addr_out <= '0;
            data_out <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (start) begin
                        addr_out <= start_addr;
                        data_out <= start_data;
                        wr_out   <= 1'b1;
                        state    <= M_SETUP;
                    end
                end
                M_SETUP: begin
                    req_out <= 1'b1;
                    state   <= M_WAIT_ACK;
                end
                M_WAIT_ACK: begin
                    if (ack_s) begin
                        req_out <= 1'b0;
                        wr_out  <= 1'b0;
                        state   <= M_WAIT_REL;
                    end
                end
                M_WAIT_REL: begin
                    if (!ack_s) begin
                        done  <= 1'b1;
                        state <= M_IDLE;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    assign busy = (state != M_IDLE);
endmodule

// File: rtl/hs_slave.sv
module hs_slave
    import hs_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_in,
    input  logic              wr_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              ack_out,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    slv_state_t        state;
    logic              req_s;
    logic [DATA_W-1:0] mem [DEPTH];

    hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_in),
        .q   (req_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            ack_out <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_s && wr_in) begin
                        mem[addr_in] <= data_in;
                        ack_out      <= 1'b1;
                        state        <= S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (!req_s) begin
                        ack_out <= 1'b0;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hs_write_top.sv
module hs_write_top #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    output logic              busy,
    output logic              done,
    output logic              bus_req,
    output logic              bus_ack,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    hs_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_master (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .start_data (start_data),
        .ack_in     (bus_ack),
        .req_out    (bus_req),
        .wr_out     (bus_wr),
        .addr_out   (bus_addr),
        .data_out   (bus_data),
        .busy       (busy),
        .done       (done)
    );

    hs_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_slave (
        .clk     (clk),
        .rst     (rst),
        .req_in  (bus_req),
        .wr_in   (bus_wr),
        .addr_in (bus_addr),
        .data_in (bus_data),
        .ack_out (bus_ack),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/hs_write_chk.sv
module hs_write_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data
);
    AST_REQ_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(bus_wr)); // R2
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_data))); // R3
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> bus_req); // R4
    AST_REQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> bus_ack); // R5
    AST_ACK_DROP_ON_NOREQ: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ack) |-> !bus_req); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_req && !bus_ack && !busy)); // R7
endmodule

bind hs_write_top hs_write_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_data (bus_data)
);

// File: tb/hs_write_top_tb.sv
module hs_write_top_tb;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [DW-1:0] start_data = '0;
    logic          busy, done, bus_req, bus_ack, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    int order_errs = 0;
    logic prev_req = 1'b0, prev_ack = 1'b0;
    logic [DW-1:0] model [DEPTH];

    always #10ns clk = ~clk;

    hs_write_top #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_data(start_data), .busy(busy), .done(done),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Edge-ordering monitor for R4, R5, R6
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_ack && !prev_ack && !bus_req) order_errs++;   // R4
            if (!bus_req && prev_req && !bus_ack) order_errs++;   // R5
            if (!bus_ack && prev_ack && bus_req) order_errs++;    // R6
        end
        prev_req = bus_req;
        prev_ack = bus_ack;
    end

    task automatic pulse_start(input logic [AW-1:0] a, input logic [DW-1:0] d);
        start = 1'b1; start_addr = a; start_data = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic write_and_check(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        int cyc;
        logic [DW-1:0] v;
        pulse_start(a, d);
        wait_done(cyc);
        chk(done === 1'b1, req, done, 1);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R7", {done, busy}, 0);
        model[a] = d;
        read_word(a, v);
        chk(v === d, req, v, d);
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        chk({bus_req, bus_ack, bus_wr, busy, done} === 5'b0, "R1",
            {bus_req, bus_ack, bus_wr, busy, done}, 0);
        for (int i = 0; i < DEPTH; i++) begin
            read_word(AW'(i), v);
            chk(v === '0, "R1", v, 0);
        end
    endtask

    task automatic t_launch;
        int cyc;
        pulse_start(3'd5, 8'hA5);
        chk(busy === 1'b1 && bus_wr === 1'b1 && bus_req === 1'b0, "R2",
            {busy, bus_wr, bus_req}, 3'b110);
        chk(bus_addr === 3'd5 && bus_data === 8'hA5, "R2", {bus_addr, bus_data}, {3'd5, 8'hA5});
        wait_done(cyc);
        chk(done === 1'b1, "R7", done, 1);
        chk(cyc > 4, "R7", cyc, 5);
        @(negedge clk);
        chk(done === 1'b0, "R7", done, 0);
        model[5] = 8'hA5;
    endtask

    task automatic t_ignore;
        int cyc;
        logic [DW-1:0] v;
        pulse_start(3'd1, 8'h11);
        repeat (3) @(negedge clk);
        pulse_start(3'd2, 8'h99);
        wait_done(cyc);
        chk(done === 1'b1, "R8", done, 1);
        model[1] = 8'h11;
        read_word(3'd1, v);
        chk(v === 8'h11, "R8", v, 8'h11);
        read_word(3'd2, v);
        chk(v === model[2], "R8", v, model[2]);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy || bus_req) begin
                chk(1'b0, "R8", busy, 0);
                break;
            end
        end
        read_word(3'd2, v);
        chk(v === model[2], "R8", v, model[2]);
    endtask

    task automatic t_fill;
        logic [DW-1:0] v;
        for (int i = 0; i < DEPTH; i++)
            write_and_check(AW'(i), DW'(8'h30 + i * 7), "R10");
        write_and_check(3'd3, 8'hC3, "R10");
        for (int i = 0; i < DEPTH; i++) begin
            read_word(AW'(i), v);
            chk(v === model[i], "R9", v, model[i]);
        end
    endtask

    initial begin
        #(20ns * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_launch();
        t_ignore();
        t_fill();
        chk(order_errs == 0, "R4 R5 R6", order_errs, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule